// File: doc/BRIEF.md
# DRAM Refresh Counter Self-Test Sequencer

This block exercises the refresh row counter inside an asynchronous DRAM. It drives the row strobe, both column strobes, the write and output enables, the multiplexed address and the write data. On a start pulse it first puts the counter into a known operating state. It then uses a special counter-test cycle to confirm that the counter visits every row exactly once per lap. No row address comes from the controller in that cycle: the DRAM takes the row from its own counter. The sequencer finishes by reporting done, pass or fail, the step that failed and the row index within that step.

The procedure uses one column throughout. It runs in two halves. The first half uses a base pattern and the second half uses the inverse of that pattern. Each half does four things in order:
1. Eight row-strobe-only refresh cycles.
2. One early write of the half's pattern to every row.
3. One counter-addressed read-modify-write per row. Each of these reads the pattern and writes back its complement.
4. One normal read of every row, expecting the complement.

A counter that skips or repeats a row leaves a row that holds the wrong value, and a later read catches it. Every phase length is a parameter counted in clock cycles.

Top module: `rcst_seq`

## Requirements
- R1: While reset is held and after it is released, the sequencer is idle. All strobes are high (inactive), `dq_oe` is 0, and `done`, `pass` and `fail` are 0.
- R2: Each half begins with exactly 8 consecutive row-strobe-only cycles. In these cycles the row strobe falls with both column strobes high, and the column strobes stay high until the row strobe rises. No other cycle comes between these 8 cycles and the first write of the half.
- R3: Each half writes every one of the 2^ROW_W rows once with an early write. The write enable is low when both column strobes fall, and the data is `PATTERN` in the first half and `~PATTERN` in the second. The column address on `addr[COL_W-1:0]` is `COL_ADDR` at every column strobe fall in the whole run.
- R4: The counter-test cycle follows this order:
  1. Both column strobes fall.
  2. `T_CSR` cycles later the row strobe falls.
  3. The column strobes rise and then fall again while the row strobe stays low. The column is taken at this second fall.
  4. Data is read with `oe_n` low, then `we_n` falls with the complement on `dq_out`.
  Each half contains exactly 2^ROW_W such cycles.
- R5: Each half then reads every row with a normal cycle and compares the data on both byte lanes with the complement of that half's pattern.
- R6: When all checks pass, the run ends with `done`=1, `pass`=1, `fail`=0, `fail_step`=0 and `fail_row`=0. These outputs hold until the next start.
- R7: On any mismatch the sequence stops at once. It then shows `done`=1, `fail`=1, `pass`=0, `fail_step`={half, op} and `fail_row` = the row index within that step. The op codes are: 0 init, 1 write, 2 counter read-modify-write, 3 verify.
- R8: In a counter-test cycle, the second column strobe fall comes exactly `T_ACC` cycles before `we_n` falls.
- R9: A start pulse while a run is in progress has no effect. A start after `done` clears the previous result and runs the full sequence again.
- R10: `dq_oe` is high only while `we_n`, `ras_n` and the column strobes are all low. `oe_n` is low only while `we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that starts a run when the sequencer is idle |
| done | output | 1 | Run finished (passed or failed) |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_step | output | 3 | {half, op} of the failing step |
| fail_row | output | ROW_W | Row index within the failing step |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-lane column strobe, active low |
| ucas_n | output | 1 | Upper-lane column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ADDR_W | Multiplexed row/column address |
| dq_out | output | DQ_W | Write data |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DQ_W | Read data from the DRAM |

## Verification
The bench builds the sequencer with ROW_W=4, so each lap has 16 rows, and with phase lengths of 2 to 4 cycles. A full two-half run then takes about a thousand cycles, which is short enough to run the sequence to completion several times. The bench's DRAM model starts its counter at row 5 and has two injectable faults: a bit stuck at zero in one row, and a counter that skips a value once. The wrapping arithmetic on these faults gives an exact failing step and row to compare against. Every strobe cycle is counted and classified, so the bench can also confirm the number, order, column, data and spacing of the cycles.

// File: rtl/rcst_pkg.sv
package rcst_pkg;

    // operation within one half of the test
    typedef enum logic [1:0] {
        OP_INIT   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_CTRMW  = 2'd2,
        OP_VERIFY = 2'd3
    } op_e;

    // strobe phase of the cycle in flight
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ROW,   // row strobe low, row address out
        PH_COL,   // both column strobes low, normal access
        PH_CBR,   // column strobes low ahead of the row strobe
        PH_RLO,   // row strobe falls, row taken from the counter
        PH_CHI,   // column strobes back high, row strobe held low
        PH_CCOL,  // second column fall, counter-row read
        PH_RWR,   // write enable falls, complement written
        PH_PRE    // all strobes high, precharge
    } ph_e;

    typedef enum logic [1:0] {
        AS_ZERO,
        AS_ROW,
        AS_COL
    } asel_e;

    typedef struct packed {
        logic  ras_n;
        logic  cas_n;
        logic  we_n;
        logic  oe_n;
        logic  drive;
        asel_e asel;
    } strobe_t;

endpackage

// File: rtl/rcst_strobe.sv
module rcst_strobe
    import rcst_pkg::*;
(
    input  ph_e     ph,
    input  logic    is_write,
    output strobe_t sb
);
    always_comb begin
        sb = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
               drive: 1'b0, asel: AS_ZERO};
        case (ph)
            PH_ROW: begin
                sb.ras_n = 1'b0;
                sb.asel  = AS_ROW;
            end
            PH_COL: begin
                sb.ras_n = 1'b0;
                sb.cas_n = 1'b0;
                sb.we_n  = ~is_write;
                sb.oe_n  = is_write;
                sb.drive = is_write;
                sb.asel  = AS_COL;
            end
            PH_CBR: sb.cas_n = 1'b0;
            PH_RLO: begin
                sb.ras_n = 1'b0;
                sb.cas_n = 1'b0;
            end
            PH_CHI: sb.ras_n = 1'b0;
            PH_CCOL: begin
                sb.ras_n = 1'b0;
                sb.cas_n = 1'b0;
                sb.oe_n  = 1'b0;
                sb.asel  = AS_COL;
            end
            PH_RWR: begin
                sb.ras_n = 1'b0;
                sb.cas_n = 1'b0;
                sb.we_n  = 1'b0;
                sb.drive = 1'b1;
                sb.asel  = AS_COL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rcst_lanecmp.sv
module rcst_lanecmp #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int W     = LANE_W * LANES
) (
    input  logic [W-1:0] got,
    input  logic [W-1:0] want,
    output logic         any_bad
);
    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bad[i] = |(got[i*LANE_W +: LANE_W] ^ want[i*LANE_W +: LANE_W]);
    end

    assign any_bad = |lane_bad;
endmodule

// File: rtl/rcst_seq.sv
module rcst_seq
    import rcst_pkg::*;
#(
    parameter int          ROW_W    = 12,
    parameter int          ADDR_W   = 12,
    parameter int          COL_W    = 8,
    parameter int          LANE_W   = 8,
    parameter int          LANES    = 2,
    parameter int          TMR_W    = 8,
    parameter int          INIT_N   = 8,
    parameter logic [15:0] PATTERN  = 16'hA5C3,
    parameter logic [7:0]  COL_ADDR = 8'h5A,
    parameter int          T_RCD    = 3,
    parameter int          T_CAS    = 3,
    parameter int          T_RP     = 6,
    parameter int          T_CSR    = 1,
    parameter int          T_CHR    = 9,
    parameter int          T_CP     = 2,
    parameter int          T_ACC    = 9,
    parameter int          T_WP     = 2,
    localparam int         DQ_W     = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [2:0]        fail_step,
    output logic [ROW_W-1:0]  fail_row,
    output logic              ras_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in
);
    localparam logic [ROW_W-1:0] LAST_ROW  = {ROW_W{1'b1}};
    localparam logic [ROW_W-1:0] LAST_INIT = ROW_W'(INIT_N - 1);
    localparam logic [DQ_W-1:0]  PAT       = DQ_W'(PATTERN);

    typedef struct packed {
        ph_e              ph;
        logic [TMR_W-1:0] tmr;
        op_e              op;
        logic             half;
        logic [ROW_W-1:0] idx;
        logic             done;
        logic             fail;
        logic [2:0]       fstep;
        logic [ROW_W-1:0] frow;
    } st_t;

    st_t q, d;

    function automatic logic [TMR_W-1:0] span(input ph_e p);
        case (p)
            PH_ROW:  return TMR_W'(T_RCD - 1);
            PH_COL:  return TMR_W'(T_CAS - 1);
            PH_CBR:  return TMR_W'(T_CSR - 1);
            PH_RLO:  return TMR_W'(T_CHR - 1);
            PH_CHI:  return TMR_W'(T_CP - 1);
            PH_CCOL: return TMR_W'(T_ACC - 1);
            PH_RWR:  return TMR_W'(T_WP - 1);
            PH_PRE:  return TMR_W'(T_RP - 1);
            default: return '0;
        endcase
    endfunction

    function automatic ph_e first_ph(input op_e o);
        return (o == OP_CTRMW) ? PH_CBR : PH_ROW;
    endfunction

    strobe_t          sb;
    logic [DQ_W-1:0]  pat_h;
    logic [DQ_W-1:0]  want;
    logic             mism;

    assign pat_h = q.half ? ~PAT : PAT;
    assign want  = (q.ph == PH_CCOL) ? pat_h : ~pat_h;

    rcst_strobe u_strobe (
        .ph       (q.ph),
        .is_write (q.op == OP_WRITE),
        .sb       (sb)
    );

    rcst_lanecmp #(.LANE_W(LANE_W), .LANES(LANES)) u_cmp (
        .got     (dq_in),
        .want    (want),
        .any_bad (mism)
    );

    always_comb begin
        d = q;
        if (q.ph == PH_IDLE) begin
            if (start) begin
                d       = '0;
                d.op    = OP_INIT;
                d.ph    = PH_ROW;
                d.tmr   = span(PH_ROW);
            end
        end else if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
        end else begin
            case (q.ph)
                PH_ROW: d.ph = (q.op == OP_INIT) ? PH_PRE : PH_COL;
                PH_COL: begin
                    if (q.op == OP_VERIFY && mism) begin
                        d.fail  = 1'b1;
                        d.done  = 1'b1;
                        d.fstep = {q.half, q.op};
                        d.frow  = q.idx;
                        d.ph    = PH_IDLE;
                    end else begin
                        d.ph = PH_PRE;
                    end
                end
                PH_CBR: d.ph = PH_RLO;
                PH_RLO: d.ph = PH_CHI;
                PH_CHI: d.ph = PH_CCOL;
                PH_CCOL: begin
                    if (mism) begin
                        d.fail  = 1'b1;
                        d.done  = 1'b1;
                        d.fstep = {q.half, q.op};
                        d.frow  = q.idx;
                        d.ph    = PH_IDLE;
                    end else begin
                        d.ph = PH_RWR;
                    end
                end
                PH_RWR: d.ph = PH_PRE;
                PH_PRE: begin
                    if (q.idx != ((q.op == OP_INIT) ? LAST_INIT : LAST_ROW)) begin
                        d.idx = q.idx + 1'b1;
                        d.ph  = first_ph(q.op);
                    end else if (q.op != OP_VERIFY) begin
                        d.op  = op_e'(q.op + 2'd1);
                        d.idx = '0;
                        d.ph  = first_ph(op_e'(q.op + 2'd1));
                    end else if (!q.half) begin
                        d.half = 1'b1;
                        d.op   = OP_INIT;
                        d.idx  = '0;
                        d.ph   = PH_ROW;
                    end else begin
                        d.done = 1'b1;
                        d.ph   = PH_IDLE;
                    end
                end
                default: d.ph = PH_IDLE;
            endcase
            if (d.ph != PH_IDLE) d.tmr = span(d.ph);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ras_n     = sb.ras_n;
    assign lcas_n    = sb.cas_n;
    assign ucas_n    = sb.cas_n;
    assign we_n      = sb.we_n;
    assign oe_n      = sb.oe_n;
    assign dq_oe     = sb.drive;
    assign dq_out    = (q.ph == PH_RWR) ? ~pat_h : pat_h;
    assign addr      = (sb.asel == AS_ROW) ? ADDR_W'(q.idx) :
                       (sb.asel == AS_COL) ? ADDR_W'(COL_ADDR) : '0;
    assign done      = q.done;
    assign fail      = q.fail;
    assign pass      = q.done & ~q.fail;
    assign fail_step = q.fstep;
    assign fail_row  = q.frow;
endmodule

// File: rtl/rcst_chk.sv
module rcst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       done,
    input logic       fail,
    input logic [2:0] fail_step,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dq_oe
);
    // R1: idle outputs while reset is applied
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (ras_n && lcas_n && ucas_n && !dq_oe && !done && !fail);
        end
    end

    // R4: a row fall with the column strobe low was preceded by a column fall
    a_r4_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !lcas_n) |-> $past(!lcas_n));

    // R10: data is driven only inside an active write
    a_r10_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !ras_n && !lcas_n && !ucas_n));

    // R10: output enable only in a read
    a_r10_oe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n);

    // R7: a failure always ends the run
    a_r7_fail_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R6: result holds until a new start
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_step)));

    // R9: strobes are parked once the run is over
    a_r9_parked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ras_n && lcas_n && we_n));
endmodule

bind rcst_seq rcst_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .fail      (fail),
    .fail_step (fail_step),
    .ras_n     (ras_n),
    .lcas_n    (lcas_n),
    .ucas_n    (ucas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe)
);

// File: tb/rcst_seq_tb.sv
module rcst_seq_tb;
    localparam int          ROW_W = 4;
    localparam int          ROWS  = 1 << ROW_W;
    localparam int          DQ_W  = 16;
    localparam logic [15:0] PAT   = 16'hA5C3;
    localparam logic [7:0]  COLA  = 8'h5A;
    localparam int T_RCD = 2, T_CAS = 3, T_RP = 2, T_CSR = 2;
    localparam int T_CHR = 3, T_CP = 2, T_ACC = 4, T_WP = 2;
    localparam int WD = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, pass, fail, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
    logic [2:0] fail_step;
    logic [ROW_W-1:0] fail_row;
    logic [11:0] addr;
    logic [DQ_W-1:0] dq_out, dq_in;

    always #2.5 clk = ~clk;

    rcst_seq #(
        .ROW_W(ROW_W), .PATTERN(PAT), .COL_ADDR(COLA),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR),
        .T_CHR(T_CHR), .T_CP(T_CP), .T_ACC(T_ACC), .T_WP(T_WP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .fail(fail), .fail_step(fail_step), .fail_row(fail_row),
        .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // ---------------- DRAM model with counter faults ----------------
    logic [DQ_W-1:0]  mem [ROWS];
    logic [ROW_W-1:0] ctr_m, act_row;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    logic cbr, saw_cas, skipped, clr = 1'b0, stuck_f = 1'b0, skip_f = 1'b0;
    int cyc = 0, cas_fall_cyc = 0;
    int ro_cnt, ro_run, wr_cnt, ct_cnt, rd_cnt;
    int col_err, wdata_err, order_err, acc_err, csr_err;

    function automatic logic [DQ_W-1:0] fix(input logic [ROW_W-1:0] r, input logic [DQ_W-1:0] v);
        return (stuck_f && r == ROW_W'(3)) ? (v & ~16'h0001) : v;
    endfunction

    assign dq_in = (!ras_n && !lcas_n && !ucas_n && we_n && !oe_n) ? mem[act_row] : '0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        p_ras <= ras_n;
        p_cas <= lcas_n;
        p_we  <= we_n;
        if (clr) begin
            ctr_m <= ROW_W'(5); skipped <= 1'b0; cbr <= 1'b0; saw_cas <= 1'b0;
            ro_cnt <= 0; ro_run <= 0; wr_cnt <= 0; ct_cnt <= 0; rd_cnt <= 0;
            col_err <= 0; wdata_err <= 0; order_err <= 0; acc_err <= 0; csr_err <= 0;
        end else begin
            if (p_ras && !ras_n) begin
                saw_cas <= 1'b0;
                if (!lcas_n) begin
                    cbr     <= 1'b1;
                    act_row <= ctr_m;
                    if (cyc - cas_fall_cyc != T_CSR) csr_err <= csr_err + 1;
                    if (skip_f && !skipped && ctr_m == ROW_W'(9)) begin
                        ctr_m <= ctr_m + ROW_W'(2); skipped <= 1'b1;
                    end else begin
                        ctr_m <= ctr_m + ROW_W'(1);
                    end
                end else begin
                    cbr     <= 1'b0;
                    act_row <= addr[ROW_W-1:0];
                end
            end
            if (p_cas && !lcas_n) begin
                cas_fall_cyc <= cyc;
                if (!ras_n) begin
                    saw_cas <= 1'b1;
                    if (addr[7:0] != COLA) col_err <= col_err + 1;
                    if (!we_n) begin
                        if (wr_cnt % ROWS == 0 && ro_run != 8) order_err <= order_err + 1;
                        if (dq_out != ((wr_cnt >= ROWS) ? ~PAT : PAT)) wdata_err <= wdata_err + 1;
                        mem[act_row] <= fix(act_row, dq_out);
                        wr_cnt <= wr_cnt + 1;
                    end else if (cbr) begin
                        ct_cnt <= ct_cnt + 1;
                    end else begin
                        rd_cnt <= rd_cnt + 1;
                    end
                end
            end
            if (p_we && !we_n && !lcas_n && !p_cas && !ras_n) begin
                mem[act_row] <= fix(act_row, dq_out);
                if (cyc - cas_fall_cyc != T_ACC) acc_err <= acc_err + 1;
            end
            if (!p_ras && ras_n) begin
                if (!saw_cas && !cbr) begin
                    ro_cnt <= ro_cnt + 1; ro_run <= ro_run + 1;
                end else begin
                    ro_run <= 0;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0, bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic stuck, input logic skip, input logic poke);
        int n;
        stuck_f = stuck; skip_f = skip;
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < WD) begin
            @(negedge clk); n++;
            if (poke && n == 150) begin
                start = 1'b1; @(negedge clk); start = 1'b0; n++;
            end
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=done", n);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clean_checks(input string tag);
        int mm = 0;
        chk({tag, " R6 done"}, int'(done), 1);
        chk({tag, " R6 pass"}, int'(pass), 1);
        chk({tag, " R6 fail"}, int'(fail), 0);
        chk({tag, " R6 step"}, int'(fail_step), 0);
        chk({tag, " R6 row"}, int'(fail_row), 0);
        chk({tag, " R2 ras-only count"}, ro_cnt, 16);
        chk({tag, " R2 init before write"}, order_err, 0);
        chk({tag, " R3 write count"}, wr_cnt, 2 * ROWS);
        chk({tag, " R3 write data"}, wdata_err, 0);
        chk({tag, " R3 column"}, col_err, 0);
        chk({tag, " R4 counter cycles"}, ct_cnt, 2 * ROWS);
        chk({tag, " R4 cas lead"}, csr_err, 0);
        chk({tag, " R8 access gap"}, acc_err, 0);
        chk({tag, " R5 read count"}, rd_cnt, 2 * ROWS);
        for (int r = 0; r < ROWS; r++) if (mem[r] != PAT) mm++;
        chk({tag, " R6 final contents"}, mm, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 ras_n", int'(ras_n), 1);
        chk("R1 cas", int'(lcas_n & ucas_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after release", int'(ras_n & ~done & ~fail & ~pass), 1);

        run_seq(1'b0, 1'b0, 1'b0);
        clean_checks("clean");

        // R7: stuck bit in row 3; counter starts at 5 so row 3 is index 14
        run_seq(1'b1, 1'b0, 1'b0);
        chk("R7 stuck fail", int'(fail), 1);
        chk("R7 stuck pass", int'(pass), 0);
        chk("R7 stuck step", int'(fail_step), 2);
        chk("R7 stuck row", int'(fail_row), 14);
        chk("R7 stopped early", int'(rd_cnt), 0);

        // R7: counter skips 10; row 5 is hit twice, second time at index 15
        run_seq(1'b0, 1'b1, 1'b0);
        chk("R7 skip fail", int'(fail), 1);
        chk("R7 skip step", int'(fail_step), 2);
        chk("R7 skip row", int'(fail_row), 15);

        // R9: restart clears the failure; mid-run start is ignored
        run_seq(1'b0, 1'b0, 1'b1);
        clean_checks("restart R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule